// File: doc/BRIEF.md
# StreamID Span Pattern Filter

This block sits beside a bank of performance counters and decides, for every counter, whether the event presented this cycle belongs to the traffic that counter is meant to watch. Each event carries a 32-bit StreamID. Each counter holds a match value and a span flag. The span flag is taken from bit 29 of that counter's event-type word. The block returns one match bit per counter. A counting stage downstream uses these bits to qualify its increments.

With the span flag clear, the whole StreamID must equal the match value. With the span flag set, the match value also carries its own don't-care width. Its lowest zero bit, together with every bit below that zero, forms a wildcard field, and only the bits above that field are compared. A match value of all ones with span set therefore accepts every StreamID, and this is the state after reset.

A platform whose counters share a single filter drives the global-mode input high. Every counter then uses the settings of counter 0, whatever its own registers hold.

Top module: `sidf_filter`

## Requirements
- R1: After reset every counter holds match value 0xFFFFFFFF with span set, so every valid event asserts all match bits until a counter is written.
- R2: With span clear, a counter's match bit is 1 exactly when all 32 StreamID bits equal its match value.
- R3: With span set, let p be the position of the lowest 0 bit of the match value. StreamID bits p down to 0 are ignored, and the bits above p must equal the match value. A match value with no 0 bit ignores every bit.
- R4: With span set and match value 0x42, StreamIDs 0x42 and 0x43 match, while 0x40, 0x41 and 0x46 do not.
- R5: A settings write (cfg_we high) loads cfg_value and bit 29 of cfg_evtype into the counter selected by cfg_idx. All other cfg_evtype bits have no effect on matching. A write whose index is not below N_CTR changes no counter.
- R6: While global_mode is 1, every counter's match bit equals the result of counter 0's settings, and its own settings are ignored.
- R7: When evt_valid is 0, all match bits are 0.
- R8: The match bits are combinational from the event inputs and the stored settings. In the cycle of a write the old settings apply, and from the next cycle the new ones apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| global_mode | input | 1 | 1: counter 0's settings govern all counters |
| cfg_we | input | 1 | Settings write strobe |
| cfg_idx | input | IDX_W | Counter selected by the write |
| cfg_evtype | input | 32 | Event-type word; bit 29 is the span flag |
| cfg_value | input | 32 | Match value to store |
| evt_valid | input | 1 | Event present this cycle |
| evt_sid | input | 32 | StreamID of the event |
| match | output | N_CTR | Per-counter filter result |

## Verification
A settings write and an event evaluation can fall in the same cycle, and the result then depends on which copy of the settings the comparator sees. The bench provokes this by presenting an event that only the old settings accept, while in the same cycle it rewrites that counter to exclude the event. It expects a hit during the write cycle and a miss one cycle later. It repeats the test with global mode on, rewriting counter 0 so that every counter flips together.

// File: rtl/sidf_pkg.sv
package sidf_pkg;
    localparam int SID_W    = 32;
    localparam int EVT_W    = 32;
    localparam int SPAN_POS = 29;

    typedef struct packed {
        logic             span;
        logic [SID_W-1:0] value;
    } flt_t;

    localparam flt_t FLT_DEFAULT = '{span: 1'b1, value: {SID_W{1'b1}}};

    // Lowest zero bit and everything beneath it.
    function automatic logic [SID_W-1:0] wild_mask(input logic [SID_W-1:0] v);
        return v ^ (v + 1'b1);
    endfunction

    function automatic logic sid_hit(input flt_t f, input logic [SID_W-1:0] sid);
        logic [SID_W-1:0] care;
        care = f.span ? ~wild_mask(f.value) : {SID_W{1'b1}};
        return ((sid ^ f.value) & care) == '0;
    endfunction
endpackage

// File: rtl/sidf_cfg_bank.sv
module sidf_cfg_bank
    import sidf_pkg::*;
#(
    parameter int N_CTR = 4,
    parameter int IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [EVT_W-1:0]        evtype,
    input  logic [SID_W-1:0]        value,
    output flt_t [N_CTR-1:0]        flt
);
    flt_t [N_CTR-1:0] flt_q;

    for (genvar g = 0; g < N_CTR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                flt_q[g] <= FLT_DEFAULT;
            end else if (we && (32'(idx) == g)) begin
                flt_q[g].span  <= evtype[SPAN_POS];
                flt_q[g].value <= value;
            end
        end
    end

    assign flt = flt_q;
endmodule

// File: rtl/sidf_sel.sv
module sidf_sel
    import sidf_pkg::*;
#(
    parameter int N_CTR = 4
) (
    input  logic             global_mode,
    input  flt_t [N_CTR-1:0] flt_own,
    output flt_t [N_CTR-1:0] flt_eff
);
    for (genvar g = 0; g < N_CTR; g++) begin : g_pick
        if (g == 0) begin : g_base
            assign flt_eff[g] = flt_own[0];
        end else begin : g_other
            assign flt_eff[g] = global_mode ? flt_own[0] : flt_own[g];
        end
    end
endmodule

// File: rtl/sidf_cmp.sv
module sidf_cmp
    import sidf_pkg::*;
#(
    parameter int N_CTR = 4
) (
    input  logic             evt_valid,
    input  logic [SID_W-1:0] evt_sid,
    input  flt_t [N_CTR-1:0] flt_eff,
    output logic [N_CTR-1:0] hit
);
    for (genvar g = 0; g < N_CTR; g++) begin : g_cmp
        assign hit[g] = evt_valid && sid_hit(flt_eff[g], evt_sid);
    end
endmodule

// File: rtl/sidf_filter.sv
module sidf_filter
    import sidf_pkg::*;
#(
    parameter int N_CTR = 4,
    localparam int IDX_W = (N_CTR > 1) ? $clog2(N_CTR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             global_mode,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [EVT_W-1:0] cfg_evtype,
    input  logic [SID_W-1:0] cfg_value,
    input  logic             evt_valid,
    input  logic [SID_W-1:0] evt_sid,
    output logic [N_CTR-1:0] match
);
    flt_t [N_CTR-1:0] flt_own;
    flt_t [N_CTR-1:0] flt_eff;

    sidf_cfg_bank #(.N_CTR(N_CTR), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
        .evtype(cfg_evtype), .value(cfg_value), .flt(flt_own)
    );

    sidf_sel #(.N_CTR(N_CTR)) u_sel (
        .global_mode(global_mode), .flt_own(flt_own), .flt_eff(flt_eff)
    );

    sidf_cmp #(.N_CTR(N_CTR)) u_cmp (
        .evt_valid(evt_valid), .evt_sid(evt_sid), .flt_eff(flt_eff), .hit(match)
    );
endmodule

// File: rtl/sidf_filter_chk.sv
module sidf_filter_chk
    import sidf_pkg::*;
#(
    parameter int N_CTR = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             global_mode,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [EVT_W-1:0] cfg_evtype,
    input  logic [SID_W-1:0] cfg_value,
    input  logic             evt_valid,
    input  logic [SID_W-1:0] evt_sid,
    input  logic [N_CTR-1:0] match
);
    logic any_wr;
    always_ff @(posedge clk) begin
        if (rst) any_wr <= 1'b0;
        else if (cfg_we) any_wr <= 1'b1;
    end

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |-> (match == '0));

    assert_reset_open_R1: assert property (@(posedge clk) disable iff (rst)
        (!any_wr && evt_valid) |-> (&match));

    assert_shared_R6: assert property (@(posedge clk) disable iff (rst)
        global_mode |-> (match == {N_CTR{match[0]}}));

    assert_exact_self_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_evtype[SPAN_POS] && 32'(cfg_idx) < N_CTR) |=>
        ((evt_valid && !global_mode && !cfg_we && evt_sid == $past(cfg_value))
            ? match[$past(cfg_idx)] : 1'b1));

    assert_exact_miss_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_evtype[SPAN_POS] && 32'(cfg_idx) < N_CTR) |=>
        ((!global_mode && !cfg_we && evt_sid != $past(cfg_value))
            ? !match[$past(cfg_idx)] : 1'b1));

    assert_pattern_self_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_evtype[SPAN_POS] && 32'(cfg_idx) < N_CTR) |=>
        ((evt_valid && !global_mode && !cfg_we && evt_sid == $past(cfg_value))
            ? match[$past(cfg_idx)] : 1'b1));
endmodule

bind sidf_filter sidf_filter_chk #(.N_CTR(N_CTR), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .global_mode(global_mode), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_evtype(cfg_evtype), .cfg_value(cfg_value),
    .evt_valid(evt_valid), .evt_sid(evt_sid), .match(match)
);

// File: tb/sidf_filter_tb.sv
module sidf_filter_tb;
    localparam int N = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic global_mode = 1'b0;
    logic cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [31:0] cfg_evtype = '0;
    logic [31:0] cfg_value = '0;
    logic evt_valid = 1'b0;
    logic [31:0] evt_sid = '0;
    logic [N-1:0] match;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_val [N];
    logic        m_span [N];

    always #4 clk = ~clk;

    sidf_filter #(.N_CTR(N)) u_dut (
        .clk(clk), .rst(rst), .global_mode(global_mode), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_evtype(cfg_evtype), .cfg_value(cfg_value),
        .evt_valid(evt_valid), .evt_sid(evt_sid), .match(match)
    );

    function automatic logic ref_one(logic [31:0] v, logic sp, logic [31:0] sid);
        logic [31:0] ign;
        logic found;
        ign = '0;
        found = 1'b0;
        if (!sp) return sid == v;
        for (int b = 0; b < 32; b++) begin
            if (!found) begin
                ign[b] = 1'b1;
                if (!v[b]) found = 1'b1;
            end
        end
        for (int b = 0; b < 32; b++)
            if (!ign[b] && sid[b] != v[b]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [N-1:0] ref_vec(logic vld, logic gm, logic [31:0] sid);
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) begin
            int s;
            s = gm ? 0 : k;
            r[k] = vld && ref_one(m_val[s], m_span[s], sid);
        end
        return r;
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: match=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic sp, logic [31:0] v, logic [31:0] junk);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_idx = IW'(idx);
        cfg_evtype = (junk & ~(32'h1 << 29)) | (32'(sp) << 29);
        cfg_value = v;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (idx < N) begin
            m_val[idx] = v;
            m_span[idx] = sp;
        end
    endtask

    task automatic ev(string req, logic vld, logic [31:0] sid);
        @(negedge clk);
        evt_valid = vld;
        evt_sid = sid;
        #1;
        chk(req, match, ref_vec(vld, global_mode, sid));
        evt_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: match=%b expected=completion", match);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < N; k++) begin
            m_val[k] = 32'hFFFF_FFFF;
            m_span[k] = 1'b1;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: defaults accept anything
        ev("R1", 1'b1, 32'h0000_0000);
        ev("R1", 1'b1, 32'hDEAD_BEEF);
        // R7: no valid, no match
        ev("R7", 1'b0, 32'h1234_5678);

        // R4: pattern 0x42 on counter 1
        wr(1, 1'b1, 32'h42, 32'h0);
        ev("R4", 1'b1, 32'h42);
        ev("R4", 1'b1, 32'h43);
        ev("R4", 1'b1, 32'h40);
        ev("R4", 1'b1, 32'h41);
        ev("R4", 1'b1, 32'h46);

        // R2: exact on counter 2, including all-ones exact
        wr(2, 1'b0, 32'hA5A5_0F0F, 32'h0000_00FF);
        ev("R2", 1'b1, 32'hA5A5_0F0F);
        ev("R2", 1'b1, 32'hA5A5_0F0E);
        wr(3, 1'b0, 32'hFFFF_FFFF, 32'h0);
        ev("R2", 1'b1, 32'hFFFF_FFFF);
        ev("R2", 1'b1, 32'h7FFF_FFFF);

        // R5: junk evtype bits, out-of-range index impossible with N=4 so check junk only
        wr(0, 1'b0, 32'h0000_1000, 32'hDFFF_FFFF);
        ev("R5", 1'b1, 32'h0000_1000);
        ev("R5", 1'b1, 32'h0000_1001);

        // R3: directed widths
        wr(0, 1'b1, 32'h7FFF_FFFF, 32'h0);
        ev("R3", 1'b1, 32'h8000_0000);
        wr(0, 1'b1, 32'hFFFF_FFFF, 32'h0);
        ev("R3", 1'b1, 32'h0123_4567);

        // R3: random pattern widths
        for (int it = 0; it < 300; it++) begin
            int y;
            int c;
            logic [63:0] v64;
            logic [31:0] v;
            logic [31:0] sid;
            y = 1 + ($urandom % 31);
            c = $urandom % N;
            v64 = {32'h0, $urandom} & ~((64'h1 << y) - 1);
            v64 = v64 | ((64'h1 << (y - 1)) - 1);
            v = v64[31:0];
            if (($urandom % 4) == 0) wr(c, 1'b0, v, $urandom);
            else wr(c, 1'b1, v, $urandom);
            sid = ($urandom % 2) ? ((v & ~((32'h1 << y) - 1)) | ($urandom & ((32'h1 << y) - 1)))
                                 : (v ^ (32'h1 << ($urandom % 32)));
            ev("R3", 1'b1, sid);
            ev("R7", 1'b0, sid);
        end

        // R6: global mode
        wr(0, 1'b1, 32'h0000_0042, 32'h0);
        wr(1, 1'b0, 32'h0000_0500, 32'h0);
        wr(2, 1'b1, 32'hFFFF_FFFF, 32'h0);
        global_mode = 1'b1;
        ev("R6", 1'b1, 32'h43);
        ev("R6", 1'b1, 32'h500);
        global_mode = 1'b0;
        ev("R6", 1'b1, 32'h500);

        // R8: write and event in the same cycle
        for (int gm = 0; gm < 2; gm++) begin
            global_mode = gm[0];
            wr(0, 1'b0, 32'h0000_0777, 32'h0);
            @(negedge clk);
            evt_valid = 1'b1;
            evt_sid = 32'h0000_0777;
            cfg_we = 1'b1;
            cfg_idx = '0;
            cfg_evtype = 32'h0;
            cfg_value = 32'h0000_0888;
            #1;
            chk("R8", match, ref_vec(1'b1, global_mode, 32'h777));
            @(posedge clk);
            #1;
            cfg_we = 1'b0;
            m_val[0] = 32'h0000_0888;
            m_span[0] = 1'b0;
            chk("R8", match, ref_vec(1'b1, global_mode, 32'h777));
            evt_valid = 1'b0;
        end
        global_mode = 1'b0;

        // R1: reset again restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < N; k++) begin
            m_val[k] = 32'hFFFF_FFFF;
            m_span[k] = 1'b1;
        end
        ev("R1", 1'b1, 32'h0000_0888);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule